// File: doc/BRIEF.md
# JTAG Boundary-Scan Test Access Port

This block is the test access port of a small controller-class device. A sixteen-state TAP controller advances on every rising edge of the test clock. The test mode select input steers it. A four-bit instruction register picks the data register that sits between the serial input and the serial output. Three data registers are provided:

- a 32-bit identification register;
- a single-flip-flop reset register that holds the device in reset;
- a boundary-scan chain with four cells per digital port pin.

Any opcode with no assigned function selects a one-bit bypass register.

The block sits between the port logic and the pads. In normal operation the pads follow the core's pull-up disable, output enable and output data. While the external-test instruction is active, the pads take their values from the chain's update latches instead. The serial output changes on the falling test-clock edge. A separate enable marks when it is meant to be driven.

Test reset (`trst`) is synchronous and active high, sampled on the rising test-clock edge.

Top module: `jbs_tap`

## Requirements
- R1: The TAP controller follows the standard sixteen-state transition graph on the TMS value sampled at each rising TCK edge. Five consecutive TMS-high cycles from any state reach Test-Logic-Reset. `trst` high forces Test-Logic-Reset.
- R2: The instruction register is 4 bits wide. Capture-IR loads 4'b0001 into it, and it shifts least significant bit first. A new instruction takes effect at Update-IR.
- R3: After reset and in Test-Logic-Reset, the active instruction is IDCODE (opcode 0x1). Under IDCODE, Capture-DR loads the 32-bit identity value, which shifts out LSB first. The fields are version [31:28], device number [27:12], manufacturer code [11:1], and bit 0 fixed at 1.
- R4: Every opcode other than 0x0, 0x1 and 0xC selects a one-bit bypass register. It captures 0, so a DR scan returns 0 followed by TDI delayed by one bit.
- R5: Opcode 0x0 (EXTEST) selects the chain, which holds four cells per pin i. Bit 4i is pull-up disable, 4i+1 is output enable, 4i+2 is output data and 4i+3 is input. Capture-DR loads the three output cells from the values currently driven to the pads and the input cell from `pin_in[i]`.
- R6: Under EXTEST, Update-DR copies the three output cells of each pin into update latches. The pads follow those latches from the moment EXTEST becomes active at Update-IR, without waiting for an Update-DR.
- R7: Under any instruction other than EXTEST, the pads follow the core's pull-up disable, output enable and output data. `core_in` always equals `pin_in`.
- R8: Opcode 0xC selects the one-bit reset register. `rst_out` equals `sys_rst_in` OR the register. The register is cleared in Test-Logic-Reset.
- R9: TDO and its enable change only on falling TCK edges. The enable is 1 exactly while the controller is in Shift-IR or Shift-DR, and the first bit presented there is bit 0 of the captured value.
- R10: The update latches change only at Update-DR under EXTEST. DR scans under other instructions leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst | input | 1 | Synchronous active-high test reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, falling-edge registered |
| tdo_oe | output | 1 | Drive enable for tdo |
| sys_rst_in | input | 1 | Other reset sources of the device |
| rst_out | output | 1 | Combined internal reset |
| core_pud | input | PINS | Core pull-up disable per pin |
| core_oe | input | PINS | Core output enable per pin |
| core_out | input | PINS | Core output data per pin |
| core_in | output | PINS | Pin level returned to the core |
| pin_in | input | PINS | Level sensed at each pin |
| pad_pud | output | PINS | Pull-up disable toward the pad |
| pad_oe | output | PINS | Output enable toward the pad |
| pad_out | output | PINS | Output data toward the pad |

## Verification
On every cycle, the assertions check these properties:

- the controller's reset entry and its hold in Test-Logic-Reset;
- the Capture-IR pattern;
- the IDCODE reload;
- the bypass capture value;
- the clearing of the reset register;
- the stability of the update latches outside an EXTEST Update-DR.

Some behaviour is visible only through the bench's scenarios:

- the serial order of every register;
- the falling-edge timing of TDO;
- the captured pin levels;
- the switch of the pads to the latches at Update-IR;
- the OR with the other reset sources.

// File: rtl/jbs_pkg.sv
`timescale 1ns/1ps
package jbs_pkg;
  localparam int IR_W = 4;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  localparam logic [IR_W-1:0] OP_EXTEST   = 4'h0;
  localparam logic [IR_W-1:0] OP_IDCODE   = 4'h1;
  localparam logic [IR_W-1:0] OP_HOLD_RST = 4'hC;
  localparam logic [IR_W-1:0] IR_CAPTURE  = 4'b0001;
endpackage

// File: rtl/jbs_tap_fsm.sv
`timescale 1ns/1ps
module jbs_tap_fsm
  import jbs_pkg::*;
(
  input  logic       tck,
  input  logic       trst,
  input  logic       tms,
  output tap_state_e state
);
  tap_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PA_DR;
      ST_PA_DR:  nxt = tms ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PA_IR;
      ST_PA_IR:  nxt = tms ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
      default:   nxt = ST_TLR;
    endcase
  end

  always_ff @(posedge tck) begin
    if (trst) state <= ST_TLR;
    else      state <= nxt;
  end

  AST_TRST_FORCES_TLR: assert property (@(posedge tck)
    trst |=> (state == ST_TLR));  // R1
  AST_TLR_HOLDS: assert property (@(posedge tck) disable iff (trst)
    (state == ST_TLR && tms) |=> (state == ST_TLR));  // R1
endmodule

// File: rtl/jbs_instr_reg.sv
`timescale 1ns/1ps
module jbs_instr_reg
  import jbs_pkg::*;
(
  input  logic            tck,
  input  logic            trst,
  input  logic            tlr,
  input  logic            cap,
  input  logic            sh,
  input  logic            upd,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_so
);
  logic [IR_W-1:0] sr_q;

  always_ff @(posedge tck) begin
    if (trst) begin
      sr_q <= IR_CAPTURE;
    end else if (cap) begin
      sr_q <= IR_CAPTURE;
    end else if (sh) begin
      sr_q <= {tdi, sr_q[IR_W-1:1]};
    end
  end

  always_ff @(posedge tck) begin
    if (trst || tlr) ir_q <= OP_IDCODE;
    else if (upd)    ir_q <= sr_q;
  end

  assign ir_so = sr_q[0];

  AST_IR_CAPTURE_PATTERN: assert property (@(posedge tck) disable iff (trst)
    cap |=> (sr_q == IR_CAPTURE));  // R2
  AST_TLR_LOADS_IDCODE: assert property (@(posedge tck) disable iff (trst)
    tlr |=> (ir_q == OP_IDCODE));  // R3
endmodule

// File: rtl/jbs_bscan_chain.sv
`timescale 1ns/1ps
module jbs_bscan_chain #(
  parameter int PINS = 4
) (
  input  logic            tck,
  input  logic            trst,
  input  logic            sel,
  input  logic            cap,
  input  logic            sh,
  input  logic            upd,
  input  logic            tdi,
  input  logic [PINS-1:0] pad_pud,
  input  logic [PINS-1:0] pad_oe,
  input  logic [PINS-1:0] pad_out,
  input  logic [PINS-1:0] pin_in,
  output logic            so,
  output logic [PINS-1:0] lat_pud,
  output logic [PINS-1:0] lat_oe,
  output logic [PINS-1:0] lat_out
);
  localparam int CELLS = 4;
  localparam int CW    = CELLS * PINS;

  logic [CW-1:0]   sr_q;
  logic [CW-1:0]   cap_vec;
  logic [PINS-1:0] sr_pud, sr_oe, sr_out;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    assign cap_vec[CELLS*i+0] = pad_pud[i];
    assign cap_vec[CELLS*i+1] = pad_oe[i];
    assign cap_vec[CELLS*i+2] = pad_out[i];
    assign cap_vec[CELLS*i+3] = pin_in[i];
    assign sr_pud[i] = sr_q[CELLS*i+0];
    assign sr_oe[i]  = sr_q[CELLS*i+1];
    assign sr_out[i] = sr_q[CELLS*i+2];
  end

  always_ff @(posedge tck) begin
    if (trst) begin
      sr_q <= '0;
    end else if (sel && cap) begin
      sr_q <= cap_vec;
    end else if (sel && sh) begin
      sr_q <= {tdi, sr_q[CW-1:1]};
    end
  end

  always_ff @(posedge tck) begin
    if (trst) begin
      lat_pud <= '0;
      lat_oe  <= '0;
      lat_out <= '0;
    end else if (sel && upd) begin
      lat_pud <= sr_pud;
      lat_oe  <= sr_oe;
      lat_out <= sr_out;
    end
  end

  assign so = sr_q[0];

  AST_LATCH_ONLY_ON_UPDATE: assert property (@(posedge tck) disable iff (trst)
    !(sel && upd) |=> ($stable(lat_pud) && $stable(lat_oe) && $stable(lat_out)));  // R10
endmodule

// File: rtl/jbs_tap.sv
`timescale 1ns/1ps
module jbs_tap
  import jbs_pkg::*;
#(
  parameter int          PINS    = 4,
  parameter logic [3:0]  VERSION = 4'h3,
  parameter logic [15:0] DEVICE  = 16'h9502,
  parameter logic [10:0] MFR     = 11'h01E
) (
  input  logic            tck,
  input  logic            trst,
  input  logic            tms,
  input  logic            tdi,
  output logic            tdo,
  output logic            tdo_oe,
  input  logic            sys_rst_in,
  output logic            rst_out,
  input  logic [PINS-1:0] core_pud,
  input  logic [PINS-1:0] core_oe,
  input  logic [PINS-1:0] core_out,
  output logic [PINS-1:0] core_in,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] pad_pud,
  output logic [PINS-1:0] pad_oe,
  output logic [PINS-1:0] pad_out
);
  localparam int          ID_W   = 32;
  localparam logic [ID_W-1:0] ID_VAL = {VERSION, DEVICE, MFR, 1'b1};

  tap_state_e      state;
  logic [IR_W-1:0] ir_q;
  logic            ir_so, chain_so;
  logic            tlr, cap_dr, sh_dr, upd_dr;
  logic            sel_ext, sel_id, sel_rst, sel_byp;
  logic [ID_W-1:0] id_q;
  logic            byp_q, hold_q;
  logic            dr_so, ser;
  logic [PINS-1:0] lat_pud, lat_oe, lat_out;

  jbs_tap_fsm u_fsm (
    .tck(tck), .trst(trst), .tms(tms), .state(state)
  );

  assign tlr    = (state == ST_TLR);
  assign cap_dr = (state == ST_CAP_DR);
  assign sh_dr  = (state == ST_SH_DR);
  assign upd_dr = (state == ST_UPD_DR);

  jbs_instr_reg u_ir (
    .tck(tck), .trst(trst), .tlr(tlr),
    .cap(state == ST_CAP_IR), .sh(state == ST_SH_IR), .upd(state == ST_UPD_IR),
    .tdi(tdi), .ir_q(ir_q), .ir_so(ir_so)
  );

  assign sel_ext = (ir_q == OP_EXTEST);
  assign sel_id  = (ir_q == OP_IDCODE);
  assign sel_rst = (ir_q == OP_HOLD_RST);
  assign sel_byp = !(sel_ext || sel_id || sel_rst);

  jbs_bscan_chain #(.PINS(PINS)) u_chain (
    .tck(tck), .trst(trst), .sel(sel_ext),
    .cap(cap_dr), .sh(sh_dr), .upd(upd_dr), .tdi(tdi),
    .pad_pud(pad_pud), .pad_oe(pad_oe), .pad_out(pad_out), .pin_in(pin_in),
    .so(chain_so), .lat_pud(lat_pud), .lat_oe(lat_oe), .lat_out(lat_out)
  );

  // identification register
  always_ff @(posedge tck) begin
    if (trst)                 id_q <= ID_VAL;
    else if (sel_id && cap_dr) id_q <= ID_VAL;
    else if (sel_id && sh_dr)  id_q <= {tdi, id_q[ID_W-1:1]};
  end

  // bypass register
  always_ff @(posedge tck) begin
    if (trst)                   byp_q <= 1'b0;
    else if (sel_byp && cap_dr) byp_q <= 1'b0;
    else if (sel_byp && sh_dr)  byp_q <= tdi;
  end

  // device-hold reset register
  always_ff @(posedge tck) begin
    if (trst || tlr)           hold_q <= 1'b0;
    else if (sel_rst && sh_dr) hold_q <= tdi;
  end

  assign rst_out = sys_rst_in | hold_q;

  always_comb begin
    if (sel_ext)      dr_so = chain_so;
    else if (sel_id)  dr_so = id_q[0];
    else if (sel_rst) dr_so = hold_q;
    else              dr_so = byp_q;
  end

  assign ser = (state == ST_SH_IR) ? ir_so : dr_so;

  always_ff @(negedge tck) begin
    if (trst) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= ser;
      tdo_oe <= (state == ST_SH_IR) || (state == ST_SH_DR);
    end
  end

  // pad override
  assign pad_pud = sel_ext ? lat_pud : core_pud;
  assign pad_oe  = sel_ext ? lat_oe  : core_oe;
  assign pad_out = sel_ext ? lat_out : core_out;
  assign core_in = pin_in;

  AST_BYPASS_CAPTURES_ZERO: assert property (@(posedge tck) disable iff (trst)
    (cap_dr && sel_byp) |=> !byp_q);  // R4
  AST_HOLD_CLEARED_IN_TLR: assert property (@(posedge tck) disable iff (trst)
    tlr |=> !hold_q);  // R8
endmodule

// File: tb/jbs_tap_tb_top.sv
`timescale 1ns/1ps
module jbs_tap_tb_top;
  localparam int PINS = 4;
  localparam logic [31:0] ID_EXP = {4'h3, 16'h9502, 11'h01E, 1'b1};

  logic tck = 1'b0, trst = 1'b1, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdo_oe, sys_rst_in = 1'b0, rst_out;
  logic [PINS-1:0] core_pud = '0, core_oe = '0, core_out = '0, pin_in = '0;
  logic [PINS-1:0] core_in, pad_pud, pad_oe, pad_out;

  always #2.5 tck = ~tck;

  jbs_tap #(.PINS(PINS)) dut_i (
    .tck(tck), .trst(trst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .sys_rst_in(sys_rst_in), .rst_out(rst_out),
    .core_pud(core_pud), .core_oe(core_oe), .core_out(core_out), .core_in(core_in),
    .pin_in(pin_in), .pad_pud(pad_pud), .pad_oe(pad_oe), .pad_out(pad_out)
  );

  typedef struct { logic [31:0] v; int n; string tag; } exp_t;
  exp_t exp_q[$];
  logic act_q[$];
  int   nchk = 0, nbad = 0;
  bit   done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // monitor: collect TDO bits and compare against queued expectations
  always @(negedge tck) begin
    #1;
    if (tdo_oe === 1'b1) act_q.push_back(tdo);
    if (exp_q.size() > 0 && act_q.size() >= exp_q[0].n) begin
      exp_t e;
      logic [31:0] got;
      e = exp_q.pop_front();
      got = '0;
      for (int k = 0; k < e.n; k++) got[k] = act_q.pop_front();
      chk(got == e.v, e.tag, got, e.v);
    end
  end

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #2;
  endtask

  task automatic ir_scan(input logic [3:0] op);
    exp_q.push_back('{32'h1, 4, "R2 capture-IR pattern"});
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int k = 0; k < 4; k++) step(k == 3, op[k]);
    step(1, 0); step(0, 0);
  endtask

  task automatic dr_scan(input int n, input logic [31:0] din, input logic [31:0] expv, input string tag);
    exp_q.push_back('{expv, n, tag});
    step(1, 0); step(0, 0); step(0, 0);
    for (int k = 0; k < n; k++) step(k == n - 1, din[k]);
    step(1, 0); step(0, 0);
  endtask

  function automatic logic [15:0] chain_exp(input logic [15:0] lat, input logic [PINS-1:0] pins);
    logic [15:0] r;
    for (int i = 0; i < PINS; i++) begin
      r[4*i+0] = lat[4*i+0];
      r[4*i+1] = lat[4*i+1];
      r[4*i+2] = lat[4*i+2];
      r[4*i+3] = pins[i];
    end
    return r;
  endfunction

  function automatic logic [11:0] pads_of(input logic [15:0] p);
    logic [11:0] r;
    for (int i = 0; i < PINS; i++) begin
      r[i]     = p[4*i+0];
      r[4+i]   = p[4*i+1];
      r[8+i]   = p[4*i+2];
    end
    return r;
  endfunction

  initial begin
    logic [15:0] p1, p2;
    logic t0;
    p1 = 16'h5A3C; p2 = 16'hC3A5;
    core_pud = 4'b0011; core_oe = 4'b1111; core_out = 4'b0101;
    repeat (3) @(posedge tck);
    @(negedge tck); #2;
    chk(tdo_oe == 1'b0, "R9 oe low in reset", {31'b0, tdo_oe}, 32'h0);
    chk(rst_out == 1'b0, "R8 rst_out idle", {31'b0, rst_out}, 32'h0);
    chk({pad_pud, pad_oe, pad_out} == {core_pud, core_oe, core_out}, "R7 pads follow core",
        {20'b0, pad_pud, pad_oe, pad_out}, {20'b0, core_pud, core_oe, core_out});
    trst = 1'b0;
    step(0, 0);
    chk(tdo_oe == 1'b0, "R9 oe low in idle", {31'b0, tdo_oe}, 32'h0);

    // R3: IDCODE active after reset, LSB first
    dr_scan(32, 32'h0, ID_EXP, "R3 identity after reset");

    // R9: tdo holds across rising edge, changes at falling edge
    step(1, 0); step(0, 0); step(0, 0);
    t0 = tdo;
    chk(t0 == ID_EXP[0], "R9 first bit is bit0", {31'b0, t0}, {31'b0, ID_EXP[0]});
    tms = 0; tdi = 0;
    @(posedge tck); #1;
    chk(tdo == t0, "R9 tdo stable after rising edge", {31'b0, tdo}, {31'b0, t0});
    @(negedge tck); #1;
    chk(tdo == ID_EXP[1], "R9 tdo updates at falling edge", {31'b0, tdo}, {31'b0, ID_EXP[1]});
    #1;
    step(1, 0); step(1, 0); step(0, 0);
    act_q.delete();

    // R4: bypass under an undefined opcode
    ir_scan(4'hF);
    dr_scan(8, 32'hB3, {24'b0, 8'hB3 << 1}, "R4 bypass delay");
    ir_scan(4'h7);
    dr_scan(8, 32'h4D, {24'b0, 8'h4D << 1}, "R4 bypass other opcode");

    // R6: EXTEST drives latches immediately
    pin_in = 4'b1010;
    ir_scan(4'h0);
    chk({pad_pud, pad_oe, pad_out} == 12'h0, "R6 latches drive on Update-IR",
        {20'b0, pad_pud, pad_oe, pad_out}, 32'h0);
    chk(core_in == pin_in, "R7 core_in follows pin", {28'b0, core_in}, {28'b0, pin_in});
    // R5: capture of driven pad values and pin levels
    dr_scan(16, {16'b0, p1}, {16'b0, chain_exp(16'h0, 4'b1010)}, "R5 first chain capture");
    chk({pad_out, pad_oe, pad_pud} == pads_of(p1), "R6 update to pads",
        {20'b0, pad_out, pad_oe, pad_pud}, {20'b0, pads_of(p1)});
    pin_in = 4'b0110;
    dr_scan(16, {16'b0, p2}, {16'b0, chain_exp(p1, 4'b0110)}, "R5 second chain capture");
    chk({pad_out, pad_oe, pad_pud} == pads_of(p2), "R6 second update",
        {20'b0, pad_out, pad_oe, pad_pud}, {20'b0, pads_of(p2)});

    // R7 / R10: leave EXTEST, scan bypass, return
    ir_scan(4'h5);
    chk({pad_pud, pad_oe, pad_out} == {core_pud, core_oe, core_out}, "R7 pads back to core",
        {20'b0, pad_pud, pad_oe, pad_out}, {20'b0, core_pud, core_oe, core_out});
    dr_scan(16, 32'hFFFF, 32'hFFFE, "R4 bypass long scan");
    ir_scan(4'h0);
    chk({pad_out, pad_oe, pad_pud} == pads_of(p2), "R10 latches kept",
        {20'b0, pad_out, pad_oe, pad_pud}, {20'b0, pads_of(p2)});

    // R8: reset register
    ir_scan(4'hC);
    dr_scan(1, 32'h1, 32'h0, "R8 hold reg initial");
    chk(rst_out == 1'b1, "R8 rst asserted", {31'b0, rst_out}, 32'h1);
    dr_scan(1, 32'h0, 32'h1, "R8 hold reg readback");
    chk(rst_out == 1'b0, "R8 rst released", {31'b0, rst_out}, 32'h0);
    sys_rst_in = 1'b1; #1;
    chk(rst_out == 1'b1, "R8 OR with other sources", {31'b0, rst_out}, 32'h1);
    sys_rst_in = 1'b0;
    dr_scan(1, 32'h1, 32'h0, "R8 hold reg set again");

    // R1: five TMS-high cycles reach Test-Logic-Reset
    for (int k = 0; k < 5; k++) step(1, 0);
    chk(rst_out == 1'b0, "R1 R8 reset reg cleared by TLR", {31'b0, rst_out}, 32'h0);
    chk({pad_pud, pad_oe, pad_out} == {core_pud, core_oe, core_out}, "R1 R3 IDCODE restored, pads on core",
        {20'b0, pad_pud, pad_oe, pad_out}, {20'b0, core_pud, core_oe, core_out});
    step(0, 0);
    dr_scan(32, 32'h0, ID_EXP, "R1 R3 identity after TMS reset");

    repeat (4) @(posedge tck);
    chk(exp_q.size() == 0 && act_q.size() == 0, "R9 no stray tdo bits",
        act_q.size(), 32'h0);
    done = 1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge tck);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule